// File: doc/BRIEF.md
# Gated Board Command Decoder

Several boards share one command bus, and each board carries one copy of this decoder. The decoder looks at every word that appears on the bus. A listen-control word holds a board-select mask. Each decoder checks the mask bit that matches its own fixed board number. If that bit is set, the decoder turns forwarding on. If it is clear, the decoder turns forwarding off. Because of this, one control word sets the listening state of every board at once.

When forwarding is on, the decoder sends each operational word to one of the board's subsections. It pulses that subsection's strobe for one cycle and presents the 16-bit payload on a shared data output. When forwarding is off, the decoder drops every word except listen-control words, with no trace on any output. If an operational word names a subsection slot that this board does not have, the decoder drops it and raises a sticky error flag.

Command word layout (20 bits): bit 19 is the listen-control flag, bits 18:16 are the subsection number, and bits 15:0 are the payload. In a listen-control word, the payload is the board-select mask.

Top module: `gated_cmd_decoder`

## Requirements
- R1: After reset, `listen_on` is 0, `sub_stb` is all zero, `sub_data` is 0 and `bad_sub` is 0.
- R2: A valid word with bit 19 = 1 changes `listen_on`, starting in the cycle after it is sampled. `listen_on` becomes 1 if payload bit BOARD_ID is 1, and 0 otherwise. No other mask bit has any effect.
- R3: A listen-control word never raises a strobe, never changes `sub_data` and never sets `bad_sub`, whether forwarding is on or off.
- R4: With `listen_on` = 1, a valid word with bit 19 = 0 and subsection number s < NUM_SUBS raises only `sub_stb[s]`. The strobe is high for exactly the cycle after the word is sampled, and `sub_data` holds the word's bits 15:0 in that cycle.
- R5: With `listen_on` = 0, operational words of any subsection number and payload do not change `sub_stb`, `sub_data` or `bad_sub`.
- R6: With `listen_on` = 1, an operational word whose subsection number is NUM_SUBS or higher raises no strobe and leaves `sub_data` unchanged. It sets `bad_sub` in the next cycle, and `bad_sub` then stays 1 until reset.
- R7: At most one strobe bit is high in any cycle. `sub_data` keeps its value in every cycle in which no strobe is high.
- R8: While `cmd_valid` is 0, nothing changes, whatever value `cmd_word` carries.
- R9: Words on consecutive cycles are each handled. An operational word sampled in the cycle right after a listen-control word already sees the new listening state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Bus word valid this cycle |
| cmd_word | input | 20 | Bus word: {listen flag, subsection[2:0], payload[15:0]} |
| sub_stb | output | NUM_SUBS | One-cycle strobe for each subsection |
| sub_data | output | 16 | Payload of the last forwarded word |
| listen_on | output | 1 | Forwarding enabled for this board |
| bad_sub | output | 1 | Sticky flag: a forwarded word named a missing subsection |

## Verification
The hardest case to reach from the ports is a listen-control word followed on the very next cycle by an operational word. This is where a decoder that uses the stale listening state would misroute or drop the word. The bench drives such back-to-back pairs in both directions (turn on then send, turn off then send). It also sweeps all sixteen single-bit masks, so that only the board's own bit can change the state. Missing subsection numbers are sent only after every present slot has been checked with the flag still clear, so the sticky flag is seen to rise exactly once and then hold.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
    localparam int PAY_W   = 16;
    localparam int SEL_W   = 3;
    localparam int CMD_W   = PAY_W + SEL_W + 1;
    localparam int CTL_BIT = CMD_W - 1;

    typedef struct packed {
        logic             ctl;
        logic [SEL_W-1:0] sel;
        logic [PAY_W-1:0] pay;
    } cmd_t;
endpackage

// File: rtl/gcd_cmd_split.sv
module gcd_cmd_split
    import gcd_pkg::*;
#(
    parameter int BOARD_ID = 5,
    parameter int NUM_SUBS = 6
) (
    input  logic             cmd_valid,
    input  cmd_t             cmd_in,
    output logic             ctl_fire,
    output logic             ctl_hit,
    output logic             op_fire,
    output logic             sel_ok,
    output logic [SEL_W-1:0] sel,
    output logic [PAY_W-1:0] pay
);
    always_comb begin
        ctl_fire = cmd_valid & cmd_in.ctl;
        op_fire  = cmd_valid & ~cmd_in.ctl;
        ctl_hit  = cmd_in.pay[BOARD_ID];
        sel_ok   = (int'(cmd_in.sel) < NUM_SUBS);
        sel      = cmd_in.sel;
        pay      = cmd_in.pay;
    end
endmodule

// File: rtl/gcd_listen_reg.sv
module gcd_listen_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_fire,
    input  logic ctl_hit,
    output logic listen
);
    typedef struct packed {
        logic on;
    } lst_t;

    lst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ctl_fire) begin
            s_d.on = ctl_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign listen = s_q.on;
endmodule

// File: rtl/gcd_sub_route.sv
module gcd_sub_route
    import gcd_pkg::*;
#(
    parameter int NUM_SUBS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fwd,
    input  logic                sel_ok,
    input  logic [SEL_W-1:0]    sel,
    input  logic [PAY_W-1:0]    pay,
    output logic [NUM_SUBS-1:0] stb,
    output logic [PAY_W-1:0]    data,
    output logic                err
);
    typedef struct packed {
        logic [NUM_SUBS-1:0] stb;
        logic [PAY_W-1:0]    data;
        logic                err;
    } rt_t;

    rt_t s_d, s_q;
    logic [NUM_SUBS-1:0] hit;

    for (genvar i = 0; i < NUM_SUBS; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i));
    end

    always_comb begin
        s_d     = s_q;
        s_d.stb = '0;
        if (fwd) begin
            if (sel_ok) begin
                s_d.stb  = hit;
                s_d.data = pay;
            end else begin
                s_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stb  = s_q.stb;
    assign data = s_q.data;
    assign err  = s_q.err;
endmodule

// File: rtl/gated_cmd_decoder.sv
module gated_cmd_decoder
    import gcd_pkg::*;
#(
    parameter int BOARD_ID = 5,
    parameter int NUM_SUBS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [CMD_W-1:0]    cmd_word,
    output logic [NUM_SUBS-1:0] sub_stb,
    output logic [PAY_W-1:0]    sub_data,
    output logic                listen_on,
    output logic                bad_sub
);
    logic             ctl_fire, ctl_hit, op_fire, sel_ok, fwd;
    logic [SEL_W-1:0] sel;
    logic [PAY_W-1:0] pay;

    gcd_cmd_split #(.BOARD_ID(BOARD_ID), .NUM_SUBS(NUM_SUBS)) u_split (
        .cmd_valid (cmd_valid),
        .cmd_in    (cmd_t'(cmd_word)),
        .ctl_fire  (ctl_fire),
        .ctl_hit   (ctl_hit),
        .op_fire   (op_fire),
        .sel_ok    (sel_ok),
        .sel       (sel),
        .pay       (pay)
    );

    gcd_listen_reg u_listen (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_fire (ctl_fire),
        .ctl_hit  (ctl_hit),
        .listen   (listen_on)
    );

    assign fwd = op_fire & listen_on;

    gcd_sub_route #(.NUM_SUBS(NUM_SUBS)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwd    (fwd),
        .sel_ok (sel_ok),
        .sel    (sel),
        .pay    (pay),
        .stb    (sub_stb),
        .data   (sub_data),
        .err    (bad_sub)
    );
endmodule

// File: rtl/gated_cmd_decoder_chk.sv
module gated_cmd_decoder_chk
    import gcd_pkg::*;
#(
    parameter int NUM_SUBS = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [CMD_W-1:0]    cmd_word,
    input logic [NUM_SUBS-1:0] sub_stb,
    input logic [PAY_W-1:0]    sub_data,
    input logic                listen_on,
    input logic                bad_sub
);
    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_stb));

    p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_stb == '0) |-> $stable(sub_data));

    p_stb_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_stb != '0) |-> ($past(listen_on) && $past(cmd_valid) && !$past(cmd_word[CTL_BIT])));

    p_fwd_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_stb != '0) |-> (sub_data == $past(cmd_word[PAY_W-1:0])));

    p_ctl_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[CTL_BIT]) |=> (sub_stb == '0));

    p_listen_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(listen_on) |-> ($past(cmd_valid) && $past(cmd_word[CTL_BIT])));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_sub |=> bad_sub);

    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bad_sub) |-> ($past(listen_on) && $past(cmd_valid) && !$past(cmd_word[CTL_BIT])));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (sub_stb == '0));
endmodule

bind gated_cmd_decoder gated_cmd_decoder_chk #(.NUM_SUBS(NUM_SUBS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .sub_stb   (sub_stb),
    .sub_data  (sub_data),
    .listen_on (listen_on),
    .bad_sub   (bad_sub)
);

// File: tb/gated_cmd_decoder_bench.sv
module gated_cmd_decoder_bench;
    localparam int BID = 5;
    localparam int NS  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [19:0]   cmd_word = '0;
    logic [NS-1:0] sub_stb;
    logic [15:0]   sub_data;
    logic          listen_on;
    logic          bad_sub;

    int total = 0;
    int bad = 0;

    logic [NS-1:0] e_stb = '0;
    logic [15:0]   e_data = '0;
    logic          e_lst = 1'b0;
    logic          e_err = 1'b0;

    gated_cmd_decoder #(.BOARD_ID(BID), .NUM_SUBS(NS)) u_gated_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .sub_stb(sub_stb), .sub_data(sub_data), .listen_on(listen_on), .bad_sub(bad_sub)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(sub_stb == e_stb, req, "stb", 32'(sub_stb), 32'(e_stb));
        chk(sub_data == e_data, req, "data", 32'(sub_data), 32'(e_data));
        chk(listen_on == e_lst, req, "listen", 32'(listen_on), 32'(e_lst));
        chk(bad_sub == e_err, req, "err", 32'(bad_sub), 32'(e_err));
    endtask

    // one word, sampled at the next posedge; outputs checked 1 ns later
    task automatic send(input logic ctl, input int sel, input logic [15:0] pay, input string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = {ctl, 3'(sel), pay};
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        e_stb = '0;
        if (ctl) begin
            e_lst = pay[BID];
        end else if (e_lst) begin
            if (sel < NS) begin
                e_stb  = NS'(1) << sel;
                e_data = pay;
            end else begin
                e_err = 1'b1;
            end
        end
        check_all(req);
    endtask

    task automatic idle(input logic [19:0] junk, input string req);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = junk;
        @(posedge clk);
        #1;
        e_stb = '0;
        check_all(req);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R5: forwarding off, sweep every subsection number
        for (int s = 0; s < 8; s++) begin
            send(1'b0, s, 16'h1111 * 16'(s + 1), "R5");
        end
        // R2: mask without own bit keeps it off
        send(1'b1, 0, ~(16'h1 << BID), "R2");
        // R8: idle with a would-be enable on the bus
        idle({1'b1, 3'd0, 16'hFFFF}, "R8");
        // R2: every single-bit mask
        for (int b = 0; b < 16; b++) begin
            send(1'b1, 0, 16'h1 << b, "R2");
        end
        send(1'b1, 0, 16'h1 << BID, "R2");

        // R4: every present slot with several payloads
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < NS; s++) begin
                logic [15:0] v;
                v = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF :
                    (p == 2) ? 16'hA5C3 : 16'(s * 16'h0923 + 16'h0101);
                send(1'b0, s, v, "R4");
            end
        end
        // R8: idle with junk operational word
        idle({1'b0, 3'd2, 16'hDEAD}, "R8");
        // R3: control word while on does not strobe or touch data
        send(1'b1, 7, 16'hFFFF, "R3");

        // R6: missing slots set sticky flag
        for (int s = NS; s < 8; s++) begin
            send(1'b0, s, 16'h7777, "R6");
        end
        send(1'b0, 1, 16'h4242, "R6");
        idle('0, "R6");

        // R9: off then immediately operational word (dropped)
        send(1'b1, 0, 16'h0000, "R9");
        send(1'b0, 3, 16'hBEEF, "R9");
        // R9: on then immediately operational word (forwarded)
        send(1'b1, 0, 16'h1 << BID, "R9");
        send(1'b0, 4, 16'hCAFE, "R9");
        send(1'b0, 0, 16'h0F0F, "R9");
        // R7: back-to-back slots, strobe moves
        send(1'b0, NS - 1, 16'h1234, "R7");
        idle('0, "R7");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule